// File: doc/BRIEF.md
# Packet Ready Tracker

This block sits beside a multi-queue FIFO and tells the read side which queues hold at least one whole packet. Writers tag words with two in-band marker bits: a start marker (data bit 34) and an end marker (data bit 35). The same two bits come back on the read bus when the words leave the queue. The block keeps one saturating count of complete packets per queue. A write of an end marker that closes an open packet raises the count. A read of an end marker lowers it.

Two outputs follow from the counts. An active-low ready flag covers the queue now addressed on the read side. An active-low per-queue vector normally passes the storage's almost-empty status through unchanged. In packet mode that vector shows packet-ready status instead. Packet mode is captured while reset is held. It turns on only if the mode request is asserted and both ports are configured at full width. The storage itself lies outside this block. It passes the marker bits and the queue addresses of each accepted write and read.

Top module: `pkt_ready_tracker`

## Requirements
- R1: Packet mode is captured on clock edges while `rst_n` is low, as `cfg_pkt_mode AND cfg_wide_ports`. Changes to either input after reset has no effect. With packet mode off, no count moves, `pr_n` stays 1 and `stat_n` equals `ae_n`.
- R2: A write with the start marker (bit 34, `wr_sop`) opens a packet in queue `wr_qid`. A later write to that queue with the end marker (bit 35, `wr_eop`) closes it and adds one to its count. Words in between carry no markers and do not change the count.
- R3: A single write that carries both markers counts as one complete packet.
- R4: An end marker written while the queue has no open packet is ignored.
- R5: A second start marker while a packet is open restarts that packet. The following end marker adds exactly one to the count.
- R6: A read with the end marker (`rd_eop`) from queue `rd_qid` takes one from that queue's count. At zero the count stays at zero.
- R7: In packet mode, `pr_n` is 0 exactly when the queue selected by `rd_qid` has a nonzero count. It follows the count in the cycle after the edge that changed it.
- R8: In packet mode, bit q of `stat_n` is 0 exactly when queue q has a nonzero count.
- R9: A partial reset (`prs_valid`, `prs_qid`) clears that queue's count and open-packet state. It wins over a write or read to the same queue in the same cycle.
- R10: A count saturates at 2^CW-1. Further completed packets are not counted.
- R11: A write that completes a packet and a read of an end marker on the same queue in the same cycle leave the count unchanged. Activity on one queue never changes another queue's count.
- R12: After reset every count is zero and no packet is open. In packet mode `pr_n` is 1 and `stat_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset; packet mode is captured while it is low |
| cfg_pkt_mode | input | 1 | Packet mode request |
| cfg_wide_ports | input | 1 | Both ports configured full width |
| wr_valid | input | 1 | A word is accepted into a queue this cycle |
| wr_qid | input | QW | Queue receiving the word |
| wr_sop | input | 1 | Start marker of the written word |
| wr_eop | input | 1 | End marker of the written word |
| rd_valid | input | 1 | A word leaves a queue this cycle |
| rd_qid | input | QW | Queue selected on the read side |
| rd_eop | input | 1 | End marker of the read word |
| prs_valid | input | 1 | Partial reset strobe |
| prs_qid | input | QW | Queue being partially reset |
| ae_n | input | NQ | Almost-empty status per queue from the storage, active low |
| pr_n | output | 1 | Packet ready for `rd_qid`, active low |
| stat_n | output | NQ | Per-queue status vector, active low |

## Verification
Complete packets are written in several shapes to separate counting from marker tracking. Shapes include start–middle–end runs, single words carrying both markers, stray end markers and doubled start markers. Only a packet closed after an open start should move the count. Exact count values are inferred by draining end markers and noting which read turns the ready flag high. This approach also exposes underflow wrap and saturation at the top of the count. Coincident events on one queue probe the precedence between updates: a write completion with a read, and a partial reset with a write. Repeated resets with different mode inputs show that the almost-empty pass-through holds and that later mode changes are ignored.

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker #(
  parameter int NQ = 8,
  parameter int CW = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pkt_mode,
  input  logic          cfg_wide_ports,
  input  logic          wr_valid,
  input  logic [QW-1:0] wr_qid,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          rd_valid,
  input  logic [QW-1:0] rd_qid,
  input  logic          rd_eop,
  input  logic          prs_valid,
  input  logic [QW-1:0] prs_qid,
  input  logic [NQ-1:0] ae_n,
  output logic          pr_n,
  output logic [NQ-1:0] stat_n
);
  localparam int NSEL = 1 << QW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic pkt_en;
  logic [NSEL-1:0] ready;
  logic [NQ-1:0][CW-1:0] cnt;
  logic [NQ-1:0] open_q;

  always_ff @(posedge clk)
    if (!rst_n) pkt_en <= cfg_pkt_mode & cfg_wide_ports;

  for (genvar q = 0; q < NSEL; q++) begin : g_q
    if (q < NQ) begin : g_live
      logic wr_hit, rd_hit, clr, inc, dec;
      assign wr_hit = pkt_en & wr_valid & (wr_qid == QW'(q));
      assign rd_hit = pkt_en & rd_valid & (rd_qid == QW'(q));
      assign clr    = prs_valid & (prs_qid == QW'(q));
      assign inc    = wr_hit & wr_eop & (open_q[q] | wr_sop) & (cnt[q] != CMAX);
      assign dec    = rd_hit & rd_eop & (cnt[q] != '0);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cnt[q]    <= '0;
          open_q[q] <= 1'b0;
        end else if (clr || !pkt_en) begin
          cnt[q]    <= '0;
          open_q[q] <= 1'b0;
        end else begin
          if (inc && !dec) cnt[q] <= cnt[q] + CW'(1);
          else if (dec && !inc) cnt[q] <= cnt[q] - CW'(1);
          if (wr_hit) open_q[q] <= wr_eop ? 1'b0 : (wr_sop | open_q[q]);
        end

      assign ready[q] = (cnt[q] != '0);

      p_prs_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt[q] == '0) && !open_q[q]);

      p_step_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_en |=> (cnt[q] == $past(cnt[q])) || (cnt[q] == $past(cnt[q]) + CW'(1)) ||
                   (cnt[q] == $past(cnt[q]) - CW'(1)) || (cnt[q] == '0));

      p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[q] == '0) && !(wr_valid && wr_eop && wr_qid == QW'(q)) |=> (cnt[q] == '0));

      p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[q] == CMAX) && !(rd_valid && rd_eop && rd_qid == QW'(q)) && !clr
        |=> (cnt[q] == CMAX));

      p_idle_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_en |=> (cnt[q] == '0));
    end else begin : g_pad
      assign ready[q] = 1'b0;
    end
  end

  assign pr_n   = ~(pkt_en & ready[rd_qid]);
  assign stat_n = pkt_en ? ~ready[NQ-1:0] : ae_n;

  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pkt_en));

  p_flag_matches_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_en && (int'(rd_qid) < NQ) |-> (pr_n == stat_n[rd_qid]));
endmodule

// File: tb/tb_pkt_ready_tracker.sv
module tb_pkt_ready_tracker;
  localparam int PERIOD = 10;
  localparam int NQ = 8;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, cfg_pkt_mode = 1, cfg_wide_ports = 1;
  logic wr_valid = 0, wr_sop = 0, wr_eop = 0, rd_valid = 0, rd_eop = 0, prs_valid = 0;
  logic [2:0] wr_qid = 0, rd_qid = 0, prs_qid = 0;
  logic [NQ-1:0] ae_n = 8'hA5;
  logic pr_n;
  logic [NQ-1:0] stat_n;
  int checks = 0, errors = 0;
  bit done = 0;

  pkt_ready_tracker #(.NQ(NQ), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pkt_mode(cfg_pkt_mode), .cfg_wide_ports(cfg_wide_ports),
    .wr_valid(wr_valid), .wr_qid(wr_qid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .rd_valid(rd_valid), .rd_qid(rd_qid), .rd_eop(rd_eop),
    .prs_valid(prs_valid), .prs_qid(prs_qid), .ae_n(ae_n),
    .pr_n(pr_n), .stat_n(stat_n));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_pr(input string tag, input int q, input logic exp);
    rd_qid = 3'(q);
    #1;
    chk(tag, {31'd0, pr_n}, {31'd0, exp});
  endtask

  task automatic cyc(input logic wv, input int wq, input logic ws, input logic we,
                     input logic rv, input int rq, input logic re,
                     input logic pv, input int pq);
    wr_valid = wv; wr_qid = 3'(wq); wr_sop = ws; wr_eop = we;
    rd_valid = rv; rd_qid = 3'(rq); rd_eop = re;
    prs_valid = pv; prs_qid = 3'(pq);
    @(posedge clk); @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0; rd_valid = 0; rd_eop = 0; prs_valid = 0;
  endtask

  task automatic wr(input int q, input logic s, input logic e);
    cyc(1, q, s, e, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input int q, input logic e);
    cyc(0, 0, 0, 0, 1, q, e, 0, 0);
  endtask

  task automatic do_reset(input logic mode, input logic wide);
    rst_n = 0; cfg_pkt_mode = mode; cfg_wide_ports = wide;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1, 1);
    chk("R12 stat after reset", 32'(stat_n), 32'hFF);
    for (int q = 0; q < NQ; q++) chk_pr("R12 pr_n after reset", q, 1'b1);
  endtask

  task automatic t_basic;
    wr(2, 1, 0);
    chk_pr("R2 open only", 2, 1'b1);
    wr(2, 0, 0);
    chk_pr("R2 middle word", 2, 1'b1);
    wr(2, 0, 1);
    chk_pr("R7 ready after eop", 2, 1'b0);
    chk("R8 stat bit 2", 32'(stat_n), 32'hFB);
    chk_pr("R11 other queue untouched", 3, 1'b1);
    rd(2, 0);
    chk_pr("R6 non-eop read keeps count", 2, 1'b0);
    rd(2, 1);
    chk_pr("R6 drained", 2, 1'b1);
    chk("R8 stat clear", 32'(stat_n), 32'hFF);
  endtask

  task automatic t_single;
    wr(5, 1, 1);
    chk_pr("R3 one-word packet", 5, 1'b0);
    rd(5, 1);
    chk_pr("R3 one-word drained", 5, 1'b1);
  endtask

  task automatic t_orphan;
    wr(1, 0, 1);
    chk_pr("R4 stray eop", 1, 1'b1);
    wr(1, 1, 0); wr(1, 0, 1); wr(1, 0, 1);
    rd(1, 1);
    chk_pr("R4 eop after close ignored", 1, 1'b1);
  endtask

  task automatic t_restart;
    wr(3, 1, 0); wr(3, 0, 0); wr(3, 1, 0); wr(3, 0, 1);
    chk_pr("R5 restarted packet ready", 3, 1'b0);
    rd(3, 1);
    chk_pr("R5 exactly one packet", 3, 1'b1);
  endtask

  task automatic t_count;
    for (int i = 0; i < 3; i++) begin wr(0, 1, 0); wr(0, 0, 1); end
    rd(0, 1); rd(0, 1);
    chk_pr("R6 one left of three", 0, 1'b0);
    rd(0, 1);
    chk_pr("R6 three drained", 0, 1'b1);
    rd(0, 1);
    chk_pr("R6 read at zero", 0, 1'b1);
    wr(0, 1, 1);
    rd(0, 1);
    chk_pr("R6 no wrap below zero", 0, 1'b1);
  endtask

  task automatic t_prs;
    wr(4, 1, 1); wr(4, 1, 0);
    cyc(1, 4, 0, 1, 0, 0, 0, 1, 4);
    chk_pr("R9 prs beats write", 4, 1'b1);
    wr(4, 0, 1);
    chk_pr("R9 open state cleared", 4, 1'b1);
    wr(6, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 4);
    chk_pr("R9 other queue kept", 6, 1'b0);
    rd(6, 1);
  endtask

  task automatic t_same_cycle;
    wr(6, 1, 1); wr(6, 1, 0);
    cyc(1, 6, 0, 1, 1, 6, 1, 0, 0);
    chk_pr("R11 inc and dec together", 6, 1'b0);
    rd(6, 1);
    chk_pr("R11 count was one", 6, 1'b1);
    chk_pr("R11 neighbour idle", 7, 1'b1);
  endtask

  task automatic t_sat;
    for (int i = 0; i < 260; i++) wr(7, 1, 1);
    for (int i = 0; i < 254; i++) rd(7, 1);
    chk_pr("R10 saturated count left one", 7, 1'b0);
    rd(7, 1);
    chk_pr("R10 saturated at max", 7, 1'b1);
  endtask

  task automatic t_mode;
    do_reset(1, 0);
    wr(0, 1, 1);
    chk_pr("R1 narrow ports block mode", 0, 1'b1);
    chk("R1 ae passthrough", 32'(stat_n), 32'hA5);
    cfg_wide_ports = 1;
    wr(0, 1, 1);
    chk_pr("R1 late cfg ignored", 0, 1'b1);
    ae_n = 8'h3C; #1;
    chk("R1 ae follows", 32'(stat_n), 32'h3C);
    do_reset(0, 1);
    wr(2, 1, 1);
    chk_pr("R1 mode off", 2, 1'b1);
    do_reset(1, 1);
    chk("R12 packet mode stat", 32'(stat_n), 32'hFF);
    wr(2, 1, 1);
    chk_pr("R1 mode on after reset", 2, 1'b0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state;
    t_basic;
    t_single;
    t_orphan;
    t_restart;
    t_count;
    t_prs;
    t_same_cycle;
    t_sat;
    t_mode;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule